// File: doc/BRIEF.md
# Integer ALU with Two-Level Operation Decode

This block is the arithmetic-logic unit of a simple 32-bit integer datapath, together with its own operation decoder. The main instruction decoder gives it a 2-bit operation class. The R-type function field is also wired in. A first decode level uses the class to choose between a forced add (address arithmetic), a forced subtract (equality compare for branches) and a lookup of the function field. A second level turns the function field into a 4-bit operation select.

The datapath has a single ripple-carry adder. For subtraction and set-on-less-than, the second operand is XOR-inverted and the carry-in is set to one. The signed overflow flag comes from the carries into and out of the sign bit, and the unsigned carry-out of the top bit is also brought out. A zero flag marks an all-zero result, so a branch can test two registers for equality. The unit is purely combinational and holds no state.

Top module: `alu_two_level`

## Requirements
- R1: When `op_class` is 00, the unit adds, whatever `func_code` holds.
- R2: When `op_class` is 01, the unit subtracts (`opnd_a` minus `opnd_b`), whatever `func_code` holds.
- R3: When `op_class` is 10 or 11, the operation comes from `func_code`:
  - 6'b100000 selects add.
  - 6'b100010 selects subtract.
  - 6'b100100 selects AND.
  - 6'b100101 selects OR.
  - 6'b101010 selects set-on-less-than.
  - Any other code selects add.
- R4: Add gives `opnd_a + opnd_b` modulo 2^32, and `carry_out` is the unsigned carry out of bit 31.
- R5: Subtract gives `opnd_a - opnd_b` modulo 2^32. It is formed as A + ~B + 1, and `carry_out` is the carry out of bit 31 of that sum, so 1 means no borrow.
- R6: For add, subtract and set-on-less-than, `ovf` is 1 exactly when the signed result of the adder does not fit in 32 bits. For AND and OR, both `ovf` and `carry_out` are 0.
- R7: AND and OR give the bitwise AND and bitwise OR of the two operands.
- R8: Set-on-less-than gives 1 in bit 0 when `opnd_a` is less than `opnd_b` as signed numbers, and 0 otherwise. This holds even when A − B overflows. Bits 31..1 are 0.
- R9: `zero` is 1 exactly when all 32 bits of `result` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| op_class | input | 2 | Operation class from the main decoder |
| func_code | input | 6 | R-type function field |
| result | output | 32 | Operation result |
| zero | output | 1 | Result is all zeros |
| ovf | output | 1 | Signed overflow of the adder path |
| carry_out | output | 1 | Unsigned carry out of the top bit of the adder path |

## Verification
Every output is a combinational function of the present inputs, so each result is due in the same cycle its inputs are applied, with zero register stages. The bench changes the inputs just after a rising clock edge. It compares `result`, `zero`, `ovf` and `carry_out` with bench-computed values at the following falling edge, half a period later, when everything has settled. No check ever looks back at an earlier vector.

// File: rtl/alu_two_level_pkg.sv
// Package: shared widths, operation select encoding and function codes
// for the two-level ALU. Assumes a 6-bit function field and 2-bit class.
package alu_two_level_pkg;

    localparam int FUNC_W  = 6;
    localparam int CLASS_W = 2;
    localparam int SEL_W   = 4;

    // Operation select passed from the decoder to the datapath
    typedef enum logic [SEL_W-1:0] {
        SEL_AND = 4'b0000,
        SEL_OR  = 4'b0001,
        SEL_ADD = 4'b0010,
        SEL_SUB = 4'b0110,
        SEL_SLT = 4'b0111
    } alu_sel_e;

    // Operation classes from the main decoder
    localparam logic [CLASS_W-1:0] CLS_ADD  = 2'b00;
    localparam logic [CLASS_W-1:0] CLS_SUB  = 2'b01;

    // Function field codes
    localparam logic [FUNC_W-1:0] FN_ADD = 6'b100000;
    localparam logic [FUNC_W-1:0] FN_SUB = 6'b100010;
    localparam logic [FUNC_W-1:0] FN_AND = 6'b100100;
    localparam logic [FUNC_W-1:0] FN_OR  = 6'b100101;
    localparam logic [FUNC_W-1:0] FN_SLT = 6'b101010;

    // Decode level 1 outcome
    typedef enum logic [1:0] {
        PATH_FORCE_ADD = 2'b00,
        PATH_FORCE_SUB = 2'b01,
        PATH_FUNC      = 2'b10
    } dec_path_e;

endpackage

// File: rtl/alu_op_decode.sv
// Module: alu_op_decode
// Two-level decoder. Level one maps the operation class to a forced add,
// a forced subtract or a function-field lookup; level two maps the
// function field to an operation select. Unknown function codes fall back
// to add. Purely combinational.
module alu_op_decode
    import alu_two_level_pkg::*;
(
    input  logic [CLASS_W-1:0] op_class,
    input  logic [FUNC_W-1:0]  func_code,
    output alu_sel_e           op_sel
);

    dec_path_e path;
    alu_sel_e  func_sel;

    // Level one: classify by operation class
    always_comb begin
        unique case (op_class)
            CLS_ADD: path = PATH_FORCE_ADD;
            CLS_SUB: path = PATH_FORCE_SUB;
            default: path = PATH_FUNC;
        endcase
    end

    // Level two: translate the function field
    always_comb begin
        case (func_code)
            FN_ADD:  func_sel = SEL_ADD;
            FN_SUB:  func_sel = SEL_SUB;
            FN_AND:  func_sel = SEL_AND;
            FN_OR:   func_sel = SEL_OR;
            FN_SLT:  func_sel = SEL_SLT;
            default: func_sel = SEL_ADD;
        endcase
    end

    // Final select: combine both levels
    always_comb begin
        case (path)
            PATH_FORCE_ADD: op_sel = SEL_ADD;
            PATH_FORCE_SUB: op_sel = SEL_SUB;
            default:        op_sel = func_sel;
        endcase
    end

    // Guard the class overrides against the function field
    always_comb begin
        if (!$isunknown({op_class, func_code})) begin
            // R1
            add_class_chk: assert (op_class != 2'b00 || op_sel == SEL_ADD)
                else $error("class 00 did not select add");
            // R2
            sub_class_chk: assert (op_class != 2'b01 || op_sel == SEL_SUB)
                else $error("class 01 did not select subtract");
        end
    end

endmodule

// File: rtl/alu_addsub.sv
// Module: alu_addsub
// Shared ripple-carry adder/subtractor. When sub_en is 1 each bit of B is
// inverted and the carry-in is 1, so A + ~B + 1 = A - B. Exposes the
// carry out of the top bit and signed overflow (carry into top XOR carry
// out of top). Assumes WIDTH >= 2.
module alu_addsub #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             sub_en,
    output logic [WIDTH-1:0] sum,
    output logic             carry_out,
    output logic             ovf
);

    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] b_eff;
    logic [WIDTH:0]   carry;

    // Conditional inversion of the second operand
    assign b_eff    = b ^ {WIDTH{sub_en}};
    // Carry-in doubles as the +1 of two's complement
    assign carry[0] = sub_en;

    // One full-adder cell per bit, chained through carry
    for (genvar i = 0; i < WIDTH; i++) begin : g_fa
        assign sum[i]     = a[i] ^ b_eff[i] ^ carry[i];
        assign carry[i+1] = (a[i] & b_eff[i]) | (carry[i] & (a[i] ^ b_eff[i]));
    end

    assign carry_out = carry[WIDTH];
    // Signed overflow from the two carries around the sign bit
    assign ovf       = carry[MSB] ^ carry[WIDTH];

    // Overflow seen from the operand and result signs
    always_comb begin
        if (!$isunknown({a, b, sub_en})) begin
            // R6
            sign_ovf_chk: assert (ovf == ((a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB])))
                else $error("overflow disagrees with operand signs");
        end
    end

endmodule

// File: rtl/alu_logic_unit.sv
// Module: alu_logic_unit
// Bitwise AND and OR of two operands, selected by or_en.
// Purely combinational; assumes the caller gates its use by operation.
module alu_logic_unit #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             or_en,
    output logic [WIDTH-1:0] y
);

    // Choose OR or AND
    always_comb begin
        y = or_en ? (a | b) : (a & b);
    end

    // OR result always covers the AND result
    always_comb begin
        if (!$isunknown({a, b, or_en})) begin
            // R7
            logic_cover_chk: assert (!or_en || ((y & (a & b)) == (a & b)))
                else $error("OR result misses AND bits");
        end
    end

endmodule

// File: rtl/alu_two_level.sv
// Module: alu_two_level (top)
// Combinational integer ALU with its own two-level operation decode.
// Supports add, subtract, AND, OR and signed set-on-less-than through one
// shared adder. Flags: zero, signed overflow, unsigned carry out; the
// adder flags are cleared for the bitwise operations. Assumes WIDTH >= 2.
module alu_two_level
    import alu_two_level_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0]   opnd_a,
    input  logic [WIDTH-1:0]   opnd_b,
    input  logic [CLASS_W-1:0] op_class,
    input  logic [FUNC_W-1:0]  func_code,
    output logic [WIDTH-1:0]   result,
    output logic               zero,
    output logic               ovf,
    output logic               carry_out
);

    localparam int MSB = WIDTH - 1;

    alu_sel_e         op_sel;
    logic             sub_en;
    logic             is_logic;
    logic [WIDTH-1:0] sum;
    logic             add_cout;
    logic             add_ovf;
    logic [WIDTH-1:0] logic_y;
    logic             less;

    alu_op_decode u_dec (
        .op_class  (op_class),
        .func_code (func_code),
        .op_sel    (op_sel)
    );

    // Subtract control shared by subtract and compare
    assign sub_en   = (op_sel == SEL_SUB) || (op_sel == SEL_SLT);
    assign is_logic = (op_sel == SEL_AND) || (op_sel == SEL_OR);

    alu_addsub #(.WIDTH(WIDTH)) u_add (
        .a         (opnd_a),
        .b         (opnd_b),
        .sub_en    (sub_en),
        .sum       (sum),
        .carry_out (add_cout),
        .ovf       (add_ovf)
    );

    alu_logic_unit #(.WIDTH(WIDTH)) u_lgc (
        .a     (opnd_a),
        .b     (opnd_b),
        .or_en (op_sel == SEL_OR),
        .y     (logic_y)
    );

    // Signed less-than: difference sign corrected by overflow
    assign less = sum[MSB] ^ add_ovf;

    // Result multiplexer
    always_comb begin
        case (op_sel)
            SEL_AND, SEL_OR: result = logic_y;
            SEL_SLT:         result = {{(WIDTH-1){1'b0}}, less};
            default:         result = sum;
        endcase
    end

    // Flags: adder flags cleared for bitwise operations
    assign zero      = (result == '0);
    assign ovf       = is_logic ? 1'b0 : add_ovf;
    assign carry_out = is_logic ? 1'b0 : add_cout;

    // Output relations across the datapath pieces
    always_comb begin
        if (!$isunknown({opnd_a, opnd_b, op_class, func_code})) begin
            // R8
            slt_upper_chk: assert (op_sel != SEL_SLT || result[MSB:1] == '0)
                else $error("compare result has upper bits set");
            // R6
            logic_flag_chk: assert (!is_logic || (!ovf && !carry_out))
                else $error("bitwise op raised adder flags");
            // R9
            zero_flag_chk: assert (!zero || !(|logic_y) || !is_logic)
                else $error("zero flag set on nonzero bitwise result");
        end
    end

endmodule

// File: tb/sim_alu_two_level.sv
// Bench for alu_two_level: directed corner cases plus seeded random
// vectors, checked against bench-computed expected values.
module sim_alu_two_level;

    localparam int W = 32;

    logic          clk = 1'b0;
    logic [W-1:0]  a, b;
    logic [1:0]    cls;
    logic [5:0]    fn;
    logic [W-1:0]  result;
    logic          zero, ovf, cout;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    alu_two_level u0 (
        .opnd_a    (a),
        .opnd_b    (b),
        .op_class  (cls),
        .func_code (fn),
        .result    (result),
        .zero      (zero),
        .ovf       (ovf),
        .carry_out (cout)
    );

    // 0 and, 1 or, 2 add, 6 sub, 7 slt (R1, R2, R3)
    function automatic int ref_op(input logic [1:0] c, input logic [5:0] f);
        if (c == 2'b00) return 2;
        if (c == 2'b01) return 6;
        case (f)
            6'b100000: return 2;
            6'b100010: return 6;
            6'b100100: return 0;
            6'b100101: return 1;
            6'b101010: return 7;
            default:   return 2;
        endcase
    endfunction

    function automatic string op_tag(input int op, input logic [1:0] c);
        if (c == 2'b00) return "R1";
        if (c == 2'b01) return "R2";
        case (op)
            0, 1:    return "R7";
            7:       return "R8";
            6:       return "R5";
            default: return "R3";
        endcase
    endfunction

    task automatic apply(input logic [W-1:0] ta, input logic [W-1:0] tb,
                         input logic [1:0] tc, input logic [5:0] tf);
        int          op;
        logic [W:0]  s33;
        logic [W-1:0] er;
        logic        eo, ec;
        string       tag;
        @(posedge clk);
        #0.5;
        a = ta; b = tb; cls = tc; fn = tf;
        op = ref_op(tc, tf);
        eo = 1'b0; ec = 1'b0;
        case (op)
            0: er = ta & tb;
            1: er = ta | tb;
            2: begin
                s33 = {1'b0, ta} + {1'b0, tb};
                er = s33[W-1:0]; ec = s33[W];
                eo = (ta[W-1] == tb[W-1]) && (er[W-1] != ta[W-1]);
            end
            default: begin
                s33 = {1'b0, ta} + {1'b0, ~tb} + 33'd1;
                er = s33[W-1:0]; ec = s33[W];
                eo = (ta[W-1] != tb[W-1]) && (er[W-1] != ta[W-1]);
                if (op == 7) er = ($signed(ta) < $signed(tb)) ? 32'd1 : 32'd0;
            end
        endcase
        tag = op_tag(op, tc);
        @(negedge clk);
        n_vec++;
        if (result !== er) begin
            n_fail++;
            $display("FAIL %s result a=%h b=%h cls=%b fn=%b actual=%h expected=%h",
                     tag, ta, tb, tc, tf, result, er);
        end
        if (zero !== (er == '0)) begin
            n_fail++;
            $display("FAIL R9 zero actual=%b expected=%b", zero, (er == '0));
        end
        if (ovf !== eo) begin
            n_fail++;
            $display("FAIL R6 ovf a=%h b=%h op=%0d actual=%b expected=%b", ta, tb, op, ovf, eo);
        end
        if (cout !== ec) begin
            n_fail++;
            $display("FAIL %s carry_out a=%h b=%h op=%0d actual=%b expected=%b",
                     (op == 2) ? "R4" : (op < 2 ? "R6" : "R5"), ta, tb, op, cout, ec);
        end
    endtask

    initial begin
        #100000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        logic [5:0] codes [5];
        codes = '{6'b100000, 6'b100010, 6'b100100, 6'b100101, 6'b101010};
        a = '0; b = '0; cls = 2'b00; fn = '0;
        void'($urandom(32'h5eed_0a1b));
        // R9 reset-like start: zero inputs add to zero
        apply(32'h0, 32'h0, 2'b00, 6'b000000);
        // R1 class 00 ignores a subtract function code
        apply(32'h0000_0005, 32'h0000_0003, 2'b00, 6'b100010);
        // R2 class 01 ignores an OR function code; equal operands give zero
        apply(32'h1234_5678, 32'h1234_5678, 2'b01, 6'b100101);
        // R4 unsigned carry out of the top bit
        apply(32'hFFFF_FFFF, 32'h0000_0001, 2'b10, 6'b100000);
        // R6 positive overflow on add
        apply(32'h7FFF_FFFF, 32'h0000_0001, 2'b10, 6'b100000);
        // R6 negative overflow on subtract
        apply(32'h8000_0000, 32'h0000_0001, 2'b10, 6'b100010);
        // R5 borrow: 0 - 1
        apply(32'h0, 32'h1, 2'b10, 6'b100010);
        // R8 compare across overflow both ways
        apply(32'h8000_0000, 32'h7FFF_FFFF, 2'b10, 6'b101010);
        apply(32'h7FFF_FFFF, 32'h8000_0000, 2'b10, 6'b101010);
        apply(32'h0000_0004, 32'h0000_0004, 2'b11, 6'b101010);
        // R7 bitwise
        apply(32'hF0F0_1234, 32'h0FF0_FFFF, 2'b10, 6'b100100);
        apply(32'hF000_0000, 32'h0000_000F, 2'b11, 6'b100101);
        apply(32'hAAAA_AAAA, 32'h5555_5555, 2'b10, 6'b100100);
        // R3 undefined code falls back to add
        apply(32'h0000_0010, 32'h0000_0020, 2'b10, 6'b111111);
        // random mix
        for (int i = 0; i < 2000; i++) begin
            logic [5:0] f;
            logic [W-1:0] ra, rb;
            ra = $urandom();
            rb = ($urandom_range(0, 7) == 0) ? ra : $urandom();
            f  = ($urandom_range(0, 3) == 0) ? 6'($urandom()) : codes[$urandom_range(0, 4)];
            apply(ra, rb, 2'($urandom()), f);
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule